// File: doc/BRIEF.md
# Indirect Effective Address Generator

This block produces the 15-bit word address used by a memory-reference instruction of a 16-bit word-addressed minicomputer. A start pulse captures the instruction's two index-mode bits, its indirect bit and its 8-bit displacement, together with the address of the instruction and the contents of the second and third accumulators. From these the block forms a base address. For a direct reference that base address is the answer.

For an indirect reference the block walks a chain of pointers through a synchronous memory port. A fetched word whose top bit is set names a further pointer. A word whose top bit is clear is the final address. Pointers read from two reserved blocks of eight low-memory words are stepped by one before use: the lower block counts up and the upper block counts down. The stepped value is written back in place. A programmable depth limit stops endless chains by raising an error pulse in place of the done pulse.

Top module: `ind_ea_gen`

## Requirements
- R1: While and after reset, `done`, `err`, `mem_req` and `mem_we` are low.
- R2: With `idx_mode` = 0 and `indirect` low, `ea` equals the displacement zero-extended to 15 bits, and `done` is high in the first cycle after the start edge.
- R3: With `idx_mode` = 1, 2 or 3 and `indirect` low, `ea` is the sign-extended displacement added to `pc` (the instruction's own address), to the low 15 bits of `ac2`, or to the low 15 bits of `ac3`, respectively. The sum wraps modulo 2^15.
- R4: With `indirect` high, the word at the base address is read. If its bit 15 is clear, `ea` is its low 15 bits, and `done` appears in cycle 3L+1 after the start edge, where L is the number of words read.
- R5: A fetched word with bit 15 set makes its low 15 bits the next address to read, and the chain continues until a word with bit 15 clear is fetched.
- R6: A word fetched from address 16 to 23 (octal 020 to 027, address bits 14:3 equal to 2) is incremented modulo 2^16, written back to the same address, and then used in place of the fetched word.
- R7: A word fetched from address 24 to 31 (octal 030 to 037, address bits 14:3 equal to 3) is decremented modulo 2^16, written back to the same address, and then used in place of the fetched word.
- R8: If the word from the `lvl_limit`-th read still has bit 15 set, `err` pulses in cycle 3*`lvl_limit`+1 and `done` does not. If `lvl_limit` is 0, an indirect request raises `err` in cycle 1 and makes no memory access.
- R9: A read at an address at or above `MEM_WORDS` yields zero, whatever is on `mem_rdata`, and no write-back is issued to such an address.
- R10: `done` and `err` each last exactly one cycle and are never high together. The port makes at most one access per cycle, and `mem_we` is only ever high with `mem_req`, at an address in the stepped-pointer blocks.
- R11: A `start` pulse that arrives while a chain is in progress is ignored, and the running request completes with its own result and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation; sampled while idle |
| idx_mode | input | 2 | 0 page zero, 1 instruction address, 2 AC2, 3 AC3 |
| indirect | input | 1 | Follow a pointer chain |
| disp | input | 8 | Displacement field |
| pc | input | 15 | Address of the instruction itself |
| ac2 | input | 16 | Second accumulator |
| ac3 | input | 16 | Third accumulator |
| lvl_limit | input | 5 | Maximum number of pointer reads |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable with request |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after the request edge |
| ea | output | 15 | Resulting effective address |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | One-cycle depth-limit strobe |

## Verification
A direct result is due one cycle after the start edge. Each word read then adds three cycles: the request, the memory's latency cycle and a decide cycle. An L-level chain therefore finishes in cycle 3L+1, and a depth error at limit N in cycle 3N+1. Every scenario counts falling edges from the start edge until `done` or `err` appears, compares that count with this formula, and then checks that the strobe has dropped one cycle later. Write-backs are checked in the bench's own memory once the strobe has been seen.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDWAIT = 2'd1,
    ST_CAPT   = 2'd2,
    ST_DECIDE = 2'd3
  } ea_state_e;
endpackage

// File: rtl/ea_base_calc.sv
module ea_base_calc #(
  parameter int AW     = 15,
  parameter int DISP_W = 8
) (
  input  logic [1:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     ac2,
  input  logic [AW-1:0]     ac3,
  output logic [AW-1:0]     base
);
  localparam int EXT = AW - DISP_W;

  logic [AW-1:0] zext_d, sext_d, rel_base;

  assign zext_d = {{EXT{1'b0}}, disp};
  assign sext_d = {{EXT{disp[DISP_W-1]}}, disp};

  always_comb begin
    unique case (mode)
      2'd1:    rel_base = pc;
      2'd2:    rel_base = ac2;
      2'd3:    rel_base = ac3;
      default: rel_base = '0;
    endcase
    base = (mode == 2'd0) ? zext_d : rel_base + sext_d;
  end
endmodule

// File: rtl/ea_ptr_adj.sv
module ea_ptr_adj #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] word,
  output logic [DW-1:0] adj,
  output logic          wb
);
  localparam logic [AW-4:0] INC_BLK = (AW-3)'(2);
  localparam logic [AW-4:0] DEC_BLK = (AW-3)'(3);

  logic in_inc, in_dec;

  assign in_inc = (addr[AW-1:3] == INC_BLK);
  assign in_dec = (addr[AW-1:3] == DEC_BLK);
  assign wb     = in_inc | in_dec;

  always_comb begin
    if (in_inc)      adj = word + DW'(1);
    else if (in_dec) adj = word - DW'(1);
    else             adj = word;
  end
endmodule

// File: rtl/ind_ea_gen.sv
module ind_ea_gen #(
  parameter int AW        = 15,
  parameter int DW        = 16,
  parameter int DISP_W    = 8,
  parameter int LVL_W     = 5,
  parameter int MEM_WORDS = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        idx_mode,
  input  logic              indirect,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     pc,
  input  logic [DW-1:0]     ac2,
  input  logic [DW-1:0]     ac3,
  input  logic [LVL_W-1:0]  lvl_limit,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     ea,
  output logic              done,
  output logic              err
);
  import ea_pkg::*;

  localparam logic [AW:0] MEM_LIM = (AW+1)'(MEM_WORDS);

  ea_state_e         state;
  logic [AW-1:0]     base, cur;
  logic [DW-1:0]     ptr, word, adj;
  logic [LVL_W-1:0]  lvl, limit_q;
  logic              rd_oor, wb;
  logic              unused_hi;

  assign unused_hi = ^{ac2[DW-1:AW], ac3[DW-1:AW]};

  function automatic logic beyond(input logic [AW-1:0] a);
    return ({1'b0, a} >= MEM_LIM);
  endfunction

  ea_base_calc #(.AW(AW), .DISP_W(DISP_W)) u_base (
    .mode (idx_mode),
    .disp (disp),
    .pc   (pc),
    .ac2  (ac2[AW-1:0]),
    .ac3  (ac3[AW-1:0]),
    .base (base)
  );

  assign word = rd_oor ? '0 : mem_rdata;

  ea_ptr_adj #(.AW(AW), .DW(DW)) u_adj (
    .addr (cur),
    .word (word),
    .adj  (adj),
    .wb   (wb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ea        <= '0;
      cur       <= '0;
      ptr       <= '0;
      lvl       <= '0;
      limit_q   <= '0;
      rd_oor    <= 1'b0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            limit_q <= lvl_limit;
            if (!indirect) begin
              ea   <= base;
              done <= 1'b1;
            end else if (lvl_limit == '0) begin
              err <= 1'b1;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= base;
              cur      <= base;
              rd_oor   <= beyond(base);
              lvl      <= LVL_W'(1);
              state    <= ST_RDWAIT;
            end
          end
        end
        ST_RDWAIT: state <= ST_CAPT;
        ST_CAPT: begin
          ptr <= adj;
          if (wb && !rd_oor) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur;
            mem_wdata <= adj;
          end
          state <= ST_DECIDE;
        end
        ST_DECIDE: begin
          if (!ptr[DW-1]) begin
            ea    <= ptr[AW-1:0];
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (lvl >= limit_q) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= ptr[AW-1:0];
            cur      <= ptr[AW-1:0];
            rd_oor   <= beyond(ptr[AW-1:0]);
            lvl      <= lvl + LVL_W'(1);
            state    <= ST_RDWAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst) !(done && err));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst) err |=> !err);
  // R10
  we_with_req_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> mem_req);
  // R6 R7
  wb_window_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[AW-1:3] == (AW-3)'(2) || mem_addr[AW-1:3] == (AW-3)'(3)));
  // R9
  wb_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ({1'b0, mem_addr} < MEM_LIM));
endmodule

// File: tb/ind_ea_gen_bench.sv
module ind_ea_gen_bench;
  localparam int MEMW = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  idx_mode = '0;
  logic        indirect = 1'b0;
  logic [7:0]  disp = '0;
  logic [14:0] pc = '0;
  logic [15:0] ac2 = '0, ac3 = '0;
  logic [4:0]  lvl_limit = 5'd16;
  logic        mem_req, mem_we;
  logic [14:0] mem_addr, ea;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        done, err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] bmem [0:MEMW-1];

  always #10 clk = ~clk;

  ind_ea_gen #(.MEM_WORDS(MEMW)) u_ind_ea_gen (
    .clk(clk), .rst(rst), .start(start), .idx_mode(idx_mode),
    .indirect(indirect), .disp(disp), .pc(pc), .ac2(ac2), .ac3(ac3),
    .lvl_limit(lvl_limit), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ea(ea), .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr[9:0]];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run(input logic [1:0] m, input bit ind, input logic [7:0] d,
                     input logic [14:0] p, input logic [15:0] a2, input logic [15:0] a3,
                     input logic [4:0] lim, input int exp_ea, input bit exp_err,
                     input int exp_cyc, input string tag, input bit inject);
    int cyc;
    @(negedge clk);
    idx_mode = m; indirect = ind; disp = d; pc = p; ac2 = a2; ac3 = a3; lvl_limit = lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!(done || err) && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 2) begin
        idx_mode = 2'd0; indirect = 1'b0; disp = 8'h11; start = 1'b1;
      end
      if (inject && cyc == 3) start = 1'b0;
    end
    chk(cyc == exp_cyc, {tag, " cycle"}, cyc, exp_cyc);
    chk(err == exp_err && done == !exp_err, {tag, " strobe kind"}, {err, done}, {exp_err, !exp_err});
    if (!exp_err) chk(ea == 15'(exp_ea), {tag, " ea"}, ea, exp_ea);
    @(negedge clk);
    chk(!done && !err, "R10 one-cycle strobe", {err, done}, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!done && !err && !mem_req && !mem_we, "R1 reset outputs", {done, err, mem_req, mem_we}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !err && !mem_req, "R1 after reset", {done, err, mem_req}, 0);
  endtask

  task automatic t_direct();
    run(2'd0, 0, 8'hF0, 15'd500, 16'h0, 16'h0, 5'd16, 'h00F0, 0, 1, "R2 page zero", 0);
  endtask

  task automatic t_relative();
    run(2'd1, 0, 8'hFE, 15'd100, 16'h0, 16'h0, 5'd16, 98, 0, 1, "R3 pc relative", 0);
    run(2'd1, 0, 8'h80, 15'd1, 16'h0, 16'h0, 5'd16, 32641, 0, 1, "R3 pc wrap", 0);
    run(2'd2, 0, 8'h05, 15'd0, 16'h8010, 16'h0, 5'd16, 'h15, 0, 1, "R3 ac2 relative", 0);
    run(2'd3, 0, 8'h02, 15'd0, 16'h0, 16'h7FFF, 5'd16, 1, 0, 1, "R3 ac3 wrap", 0);
  endtask

  task automatic t_single();
    bmem['h40] = 16'h0123;
    run(2'd0, 1, 8'h40, 15'd0, 16'h0, 16'h0, 5'd16, 'h123, 0, 4, "R4 one level", 0);
  endtask

  task automatic t_chain();
    run(2'd0, 1, 8'h50, 15'd0, 16'h0, 16'h0, 5'd16, 'h234, 0, 10, "R5 three levels", 0);
    run(2'd0, 1, 8'h50, 15'd0, 16'h0, 16'h0, 5'd3, 'h234, 0, 10, "R8 chain at limit", 0);
  endtask

  task automatic t_autoinc();
    bmem[17] = 16'h0100;
    run(2'd0, 1, 8'd17, 15'd0, 16'h0, 16'h0, 5'd16, 'h101, 0, 4, "R6 increment", 0);
    chk(bmem[17] == 16'h0101, "R6 write-back", bmem[17], 16'h0101);
    bmem[18] = 16'hFFFF;
    run(2'd0, 1, 8'd18, 15'd0, 16'h0, 16'h0, 5'd16, 0, 0, 4, "R6 wrap", 0);
    chk(bmem[18] == 16'h0000, "R6 wrap write-back", bmem[18], 0);
    bmem[23] = 16'h0007;
    run(2'd0, 1, 8'd23, 15'd0, 16'h0, 16'h0, 5'd16, 8, 0, 4, "R6 top of block", 0);
  endtask

  task automatic t_autodec();
    bmem[27] = 16'h0001;
    run(2'd0, 1, 8'd27, 15'd0, 16'h0, 16'h0, 5'd16, 0, 0, 4, "R7 decrement", 0);
    chk(bmem[27] == 16'h0000, "R7 write-back", bmem[27], 0);
    bmem[28] = 16'h0000;
    bmem[1023] = 16'h8123;
    run(2'd0, 1, 8'd28, 15'd0, 16'h0, 16'h0, 5'd16, 0, 0, 7, "R9 beyond memory reads zero", 0);
    chk(bmem[28] == 16'hFFFF, "R7 underflow write-back", bmem[28], 16'hFFFF);
    bmem[32] = 16'h0055;
    run(2'd0, 1, 8'd32, 15'd0, 16'h0, 16'h0, 5'd16, 'h55, 0, 4, "R7 outside block unchanged", 0);
    chk(bmem[32] == 16'h0055, "R7 no write outside block", bmem[32], 16'h0055);
  endtask

  task automatic t_limit();
    bmem['h90] = 16'h8090;
    run(2'd0, 1, 8'h90, 15'd0, 16'h0, 16'h0, 5'd4, 0, 1, 13, "R8 limit four", 0);
    run(2'd0, 1, 8'h90, 15'd0, 16'h0, 16'h0, 5'd0, 0, 1, 1, "R8 limit zero", 0);
    run(2'd0, 1, 8'h90, 15'd0, 16'h0, 16'h0, 5'd16, 0, 1, 49, "R8 limit sixteen", 0);
    run(2'd0, 1, 8'h50, 15'd0, 16'h0, 16'h0, 5'd2, 0, 1, 7, "R8 chain over limit", 0);
  endtask

  task automatic t_busy();
    run(2'd0, 1, 8'h50, 15'd0, 16'h0, 16'h0, 5'd16, 'h234, 0, 10, "R11 start while busy", 1);
  endtask

  initial begin
    for (int i = 0; i < MEMW; i++) bmem[i] = 16'h0;
    bmem['h50] = 16'h8060;
    bmem['h60] = 16'h8070;
    bmem['h70] = 16'h0234;
    t_reset();
    t_direct();
    t_relative();
    t_single();
    t_chain();
    t_autoinc();
    t_autodec();
    t_limit();
    t_busy();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule